// File: doc/BRIEF.md
# PMIC Voltage-Command I2C Sequencer

This block turns a voltage-change request for one of two supply channels into one I2C register write to an external power-management IC. Each request names a channel (VDD1 or VDD2) and either carries its own data byte or asks for one of two stored power-mode levels. Four configuration words define what the write contains. A slave word holds two 7-bit device addresses. A voltage-register word and a command-register word each hold two 8-bit register addresses. A pointer word holds five pointer bits per channel, and these pick the device address, the voltage register, the command register, the register kind and the stored level.

The block also drives the bus. In high-speed mode, which applies while `fs_mode` is low, every transfer opens with a master code at the preamble rate. That byte is not acknowledged. The transfer then continues with a repeated START, or with STOP and a fresh START when `rsta_off` is set, and the remaining bytes go out at the high-speed rate. In standard/fast mode the master code is left out. SCL is derived from the system clock. Each SCL quarter-period lasts a programmable number of clocks, and separate values apply to the preamble and to the high-speed phase.

Top module: `pmic_vcmd_seq`

## Requirements
- R1: The address byte is `{sa, 1'b0}`. For VDD1, pointer bit 0 selects the device address: 0 gives `slave_cfg[6:0]` and 1 gives `slave_cfg[22:16]`. For VDD2, pointer bit 16 makes the same choice.
- R2: For a plain request (`req_lvl`=0), the register byte is a voltage-register address and the data byte is `req_data`. Pointer bit 1 (VDD1) or bit 17 (VDD2) selects the address: 0 gives `volreg_cfg[7:0]` and 1 gives `volreg_cfg[23:16]`.
- R3: For a level request (`req_lvl`=1), the target depends on pointer bit 3 (VDD1) or bit 19 (VDD2). When that bit is 0, the target is the voltage register chosen as in R2. When it is 1, the target is the command register chosen by pointer bit 2 or 18 from `cmdreg_cfg[7:0]` (0) or `cmdreg_cfg[23:16]` (1). Pointer bit 4 or 20 selects the data byte: 0 gives `level0` and 1 gives `level1`.
- R4: While `fs_mode`=0, the first byte of a transfer is the master code `{5'b00001, mcode}`, and its acknowledge is not checked. While `fs_mode`=1, no master code is sent. Bytes go out MSB first, each followed by one acknowledge bit.
- R5: In high-speed mode, the master code is followed by a repeated START when `rsta_off`=0. When `rsta_off`=1 it is followed by STOP and then START. A transfer in standard/fast mode has exactly one START and one STOP.
- R6: Each SCL quarter-period lasts `div+1` clocks. `div` is `div_pre` through the end of the master-code byte and throughout standard/fast mode, and `div_hs` after the master code.
- R7: SDA changes only while SCL is low on both sides of the change. The two exceptions are the START fall and the STOP rise, which happen while SCL is high.
- R8: If the address, register or data byte is not acknowledged, the block sends STOP, sends no further bytes, pulses `err` for one cycle and does not pulse `done`.
- R9: `busy` rises in the cycle after a request is accepted. When a write completes successfully, `busy` falls in the same cycle that `done` pulses high for one cycle.
- R10: When both channels request in the same cycle, VDD1 is served. Requests that arrive while `busy` is high are ignored and never start a transfer.
- R11: After reset, and whenever the block is idle, `scl_o` and `sda_o` are 1 and `busy`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_cfg | input | 32 | Two 7-bit device addresses at [6:0] and [22:16] |
| volreg_cfg | input | 32 | Two voltage-register addresses at [7:0] and [23:16] |
| cmdreg_cfg | input | 32 | Two command-register addresses at [7:0] and [23:16] |
| ptr_cfg | input | 32 | Pointer bits: VDD1 at [4:0], VDD2 at [20:16] |
| level0 | input | 8 | Stored power-mode level 0 |
| level1 | input | 8 | Stored power-mode level 1 |
| fs_mode | input | 1 | 1 selects standard/fast mode (no master code) |
| rsta_off | input | 1 | 1 replaces the repeated START with STOP then START |
| mcode | input | 3 | Low bits of the high-speed master code |
| div_pre | input | 8 | Quarter-period divider for the preamble and standard/fast mode |
| div_hs | input | 8 | Quarter-period divider for the high-speed phase |
| req_vdd1 | input | 1 | Request for channel VDD1 |
| req_vdd2 | input | 1 | Request for channel VDD2 |
| req_lvl | input | 1 | 1 makes the request use the pointer-selected level and register kind |
| req_data | input | 8 | Data byte for a plain request |
| sda_i | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL drive (1 releases the line) |
| sda_o | output | 1 | SDA drive (1 releases the line) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a write completes |
| err | output | 1 | One-cycle pulse when a write is aborted on NACK |

## Verification
The assertions check four things on every cycle. SDA stays still while SCL is high, except at the START and STOP edges. The idle bus holds both lines high. `done` and `err` are single-cycle and mutually exclusive, and each coincides with `busy` falling. The resolved target stays frozen while a transfer runs. Only the bench scenarios can show the pointer-driven choice of address, register and data byte, the master-code and restart sequences, and the two quarter-period lengths. They also show the abort point for each NACK position, VDD1 priority, and that requests arriving mid-transfer are dropped. The bench shows these by decoding the bus as an acknowledging slave.

// File: rtl/pmic_seq_pkg.sv
package pmic_seq_pkg;
    localparam int CFG_W  = 32;
    localparam int CH_OFS = 16;
    localparam int SA_W   = 7;
    localparam int RA_W   = 8;
    localparam int PTR_W  = 5;
    // pointer bit positions inside one channel's pointer field
    localparam int PB_SA  = 0;
    localparam int PB_VR  = 1;
    localparam int PB_CR  = 2;
    localparam int PB_EN  = 3;
    localparam int PB_LV  = 4;
    localparam logic [4:0] MC_PREFIX = 5'b00001;

    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BYTE, ST_STOP} seq_st_e;
    typedef enum logic [1:0] {PH_MCODE, PH_ADDR, PH_REG, PH_DATA} byte_ph_e;

    typedef struct packed {
        logic [SA_W-1:0] sa;
        logic [RA_W-1:0] ra;
        logic [7:0]      dat;
    } xfer_tgt_t;
endpackage

// File: rtl/pmic_target_sel.sv
module pmic_target_sel
    import pmic_seq_pkg::*;
(
    input  logic [CFG_W-1:0] slave_w,
    input  logic [CFG_W-1:0] volt_w,
    input  logic [CFG_W-1:0] cmd_w,
    input  logic [CFG_W-1:0] ptr_w,
    input  logic             ch,
    input  logic             use_lvl,
    input  logic [7:0]       req_data,
    input  logic [7:0]       lvl0,
    input  logic [7:0]       lvl1,
    output xfer_tgt_t        tgt
);
    logic [PTR_W-1:0] ptr_ch [2];
    logic [SA_W-1:0]  sa_opt [2];
    logic [RA_W-1:0]  vr_opt [2];
    logic [RA_W-1:0]  cr_opt [2];

    for (genvar g = 0; g < 2; g++) begin : g_half
        assign ptr_ch[g] = ptr_w[g*CH_OFS +: PTR_W];
        assign sa_opt[g] = slave_w[g*CH_OFS +: SA_W];
        assign vr_opt[g] = volt_w[g*CH_OFS +: RA_W];
        assign cr_opt[g] = cmd_w[g*CH_OFS +: RA_W];
    end

    wire unused_cfg_bits = ^{slave_w[31:23], slave_w[15:7], volt_w[31:24], volt_w[15:8],
                             cmd_w[31:24], cmd_w[15:8], ptr_w[31:21], ptr_w[15:5]};

    always_comb begin
        logic [PTR_W-1:0] p;
        logic [RA_W-1:0]  vr;
        p  = ptr_ch[ch];
        vr = vr_opt[p[PB_VR]];
        tgt.sa = sa_opt[p[PB_SA]];
        if (use_lvl) begin
            tgt.ra  = p[PB_EN] ? cr_opt[p[PB_CR]] : vr;
            tgt.dat = p[PB_LV] ? lvl1 : lvl0;
        end else begin
            tgt.ra  = vr;
            tgt.dat = req_data;
        end
    end
endmodule

// File: rtl/pmic_qtr_timer.sv
module pmic_qtr_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == div);

    always_comb begin
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pmic_vcmd_seq.sv
module pmic_vcmd_seq
    import pmic_seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] slave_cfg,
    input  logic [CFG_W-1:0] volreg_cfg,
    input  logic [CFG_W-1:0] cmdreg_cfg,
    input  logic [CFG_W-1:0] ptr_cfg,
    input  logic [7:0]       level0,
    input  logic [7:0]       level1,
    input  logic             fs_mode,
    input  logic             rsta_off,
    input  logic [2:0]       mcode,
    input  logic [DIV_W-1:0] div_pre,
    input  logic [DIV_W-1:0] div_hs,
    input  logic             req_vdd1,
    input  logic             req_vdd2,
    input  logic             req_lvl,
    input  logic [7:0]       req_data,
    input  logic             sda_i,
    output logic             scl_o,
    output logic             sda_o,
    output logic             busy,
    output logic             done,
    output logic             err
);
    typedef struct packed {
        seq_st_e   st;
        byte_ph_e  ph;
        logic [1:0] qtr;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic       scl;
        logic       sda;
        logic       hs;
        logic       again;
        logic       fail;
        xfer_tgt_t  tgt;
        logic       done;
        logic       err;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, ph: PH_MCODE, qtr: 2'd0, bitn: 4'd0, sh: 8'd0,
                                 scl: 1'b1, sda: 1'b1, hs: 1'b0, again: 1'b0, fail: 1'b0,
                                 tgt: '0, done: 1'b0, err: 1'b0};

    seq_t      r_d, r_q;
    xfer_tgt_t sel_tgt;
    logic      tick;
    logic      cond_edge;
    logic [SA_W+RA_W+7:0] tgt_flat;

    pmic_target_sel u_sel (
        .slave_w (slave_cfg),
        .volt_w  (volreg_cfg),
        .cmd_w   (cmdreg_cfg),
        .ptr_w   (ptr_cfg),
        .ch      (!req_vdd1),
        .use_lvl (req_lvl),
        .req_data(req_data),
        .lvl0    (level0),
        .lvl1    (level1),
        .tgt     (sel_tgt)
    );

    pmic_qtr_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.st != ST_IDLE),
        .div  (r_q.hs ? div_hs : div_pre),
        .tick (tick)
    );

    function automatic logic [7:0] byte_for(byte_ph_e ph, xfer_tgt_t t, logic [2:0] mc);
        case (ph)
            PH_MCODE: return {MC_PREFIX, mc};
            PH_ADDR:  return {t.sa, 1'b0};
            PH_REG:   return t.ra;
            default:  return t.dat;
        endcase
    endfunction

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        if (r_q.st == ST_IDLE) begin
            if (req_vdd1 || req_vdd2) begin
                r_d.st    = ST_START;
                r_d.qtr   = 2'd0;
                r_d.scl   = 1'b0;
                r_d.tgt   = sel_tgt;
                r_d.hs    = 1'b0;
                r_d.again = 1'b0;
                r_d.fail  = 1'b0;
                r_d.ph    = fs_mode ? PH_ADDR : PH_MCODE;
            end
        end else if (tick) begin
            if (r_q.qtr != 2'd3) begin
                r_d.qtr = r_q.qtr + 2'd1;
                case (r_q.qtr)
                    2'd0: begin
                        // entering quarter 1: SCL low, SDA may move
                        case (r_q.st)
                            ST_START: r_d.sda = 1'b1;
                            ST_STOP:  r_d.sda = 1'b0;
                            default:  r_d.sda = r_q.bitn[3] ? 1'b1 : r_q.sh[7];
                        endcase
                    end
                    2'd1: r_d.scl = 1'b1;
                    default: begin
                        // entering quarter 3: bus conditions while SCL high
                        if (r_q.st == ST_START) r_d.sda = 1'b0;
                        if (r_q.st == ST_STOP)  r_d.sda = 1'b1;
                    end
                endcase
            end else begin
                r_d.qtr = 2'd0;
                r_d.scl = 1'b0;
                case (r_q.st)
                    ST_START: begin
                        r_d.st   = ST_BYTE;
                        r_d.bitn = 4'd0;
                        r_d.sh   = byte_for(r_q.ph, r_q.tgt, mcode);
                    end
                    ST_BYTE: begin
                        if (!r_q.bitn[3]) begin
                            r_d.bitn = r_q.bitn + 4'd1;
                            r_d.sh   = {r_q.sh[6:0], 1'b0};
                        end else if (r_q.ph == PH_MCODE) begin
                            r_d.hs = 1'b1;
                            r_d.ph = PH_ADDR;
                            if (rsta_off) begin
                                r_d.st    = ST_STOP;
                                r_d.again = 1'b1;
                            end else begin
                                r_d.st = ST_START;
                            end
                        end else if (sda_i) begin
                            r_d.st   = ST_STOP;
                            r_d.fail = 1'b1;
                        end else if (r_q.ph == PH_DATA) begin
                            r_d.st = ST_STOP;
                        end else begin
                            r_d.ph   = byte_ph_e'(r_q.ph + 2'd1);
                            r_d.bitn = 4'd0;
                            r_d.sh   = byte_for(byte_ph_e'(r_q.ph + 2'd1), r_q.tgt, mcode);
                        end
                    end
                    default: begin
                        if (r_q.again) begin
                            r_d.again = 1'b0;
                            r_d.st    = ST_START;
                        end else begin
                            r_d.st   = ST_IDLE;
                            r_d.scl  = 1'b1;
                            r_d.done = !r_q.fail;
                            r_d.err  = r_q.fail;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SEQ_RST;
        else        r_q <= r_d;
    end

    assign cond_edge = ((r_q.st == ST_START) || (r_q.st == ST_STOP)) && (r_q.qtr == 2'd3);
    assign tgt_flat  = r_q.tgt;
    assign scl_o     = r_q.scl;
    assign sda_o     = r_q.sda;
    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign err       = r_q.err;
endmodule

// File: rtl/pmic_vcmd_seq_chk.sv
module pmic_vcmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_o,
    input logic        sda_o,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        cond_edge,
    input logic [22:0] tgt_flat
);
    assert_sda_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_o != $past(sda_o)) |-> ((!scl_o && !$past(scl_o)) || (cond_edge && scl_o)));

    assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_err_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && $past(busy)));

    assert_idle_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && sda_o));

    assert_target_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (tgt_flat == $past(tgt_flat)));
endmodule

bind pmic_vcmd_seq pmic_vcmd_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_o    (scl_o),
    .sda_o    (sda_o),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .cond_edge(cond_edge),
    .tgt_flat (tgt_flat)
);

// File: tb/tb_pmic_vcmd_seq.sv
module tb_pmic_vcmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [31:0] slave_cfg = '0, volreg_cfg = '0, cmdreg_cfg = '0, ptr_cfg = '0;
    logic [7:0] level0 = '0, level1 = '0, req_data = '0;
    logic fs_mode = 1'b0, rsta_off = 1'b0, req_vdd1 = 1'b0, req_vdd2 = 1'b0, req_lvl = 1'b0;
    logic [2:0] mcode = '0;
    logic [DIV_W-1:0] div_pre = 8'd3, div_hs = 8'd1;
    logic sda_i, scl_o, sda_o, busy, done, err;
    logic slv_drv = 1'b1;
    assign sda_i = sda_o & slv_drv;

    pmic_vcmd_seq #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .slave_cfg(slave_cfg), .volreg_cfg(volreg_cfg),
        .cmdreg_cfg(cmdreg_cfg), .ptr_cfg(ptr_cfg), .level0(level0), .level1(level1),
        .fs_mode(fs_mode), .rsta_off(rsta_off), .mcode(mcode), .div_pre(div_pre),
        .div_hs(div_hs), .req_vdd1(req_vdd1), .req_vdd2(req_vdd2), .req_lvl(req_lvl),
        .req_data(req_data), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o), .busy(busy),
        .done(done), .err(err));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;
    always @(posedge clk) cyc++;

    // bus monitor and acknowledging slave
    logic [7:0] cap [8];
    logic [7:0] shv = '0;
    int cap_n, n_start, n_stop, nm_cnt, first_per, last_per, t_rise, bitcnt;
    int n_done, n_errp, n_hichg, n_both, nack_sel;
    bit hs_b;
    logic p_scl = 1'b1, p_sda = 1'b1, p_so = 1'b1;

    always @(negedge clk) begin
        logic line;
        line = sda_o & slv_drv;
        if (rst_n) begin
            if (done) n_done++;
            if (err) n_errp++;
            if (scl_o && p_scl && (sda_o != p_so)) n_hichg++;
            if ((scl_o != p_scl) && (sda_o != p_so)) n_both++;
            if (scl_o && p_scl && p_sda && !line) begin
                n_start++; bitcnt = 0;
            end else if (scl_o && p_scl && !p_sda && line) begin
                n_stop++; bitcnt = 0;
            end else if (scl_o && !p_scl) begin
                bitcnt++;
                if (bitcnt <= 8) shv = {shv[6:0], line};
                if (bitcnt == 2 && first_per < 0) first_per = cyc - t_rise;
                if (bitcnt == 9) last_per = cyc - t_rise;
                if (bitcnt == 8 && cap_n < 8) begin
                    cap[cap_n] = shv; cap_n++;
                end
                t_rise = cyc;
            end else if (!scl_o && p_scl) begin
                if (bitcnt == 8) begin
                    if (!(hs_b && cap_n == 1)) begin
                        nm_cnt++;
                        if (nm_cnt != nack_sel) slv_drv = 1'b0;
                    end
                end else if (bitcnt == 9) begin
                    slv_drv = 1'b1; bitcnt = 0;
                end
            end
        end
        p_scl = scl_o; p_so = sda_o; p_sda = sda_o & slv_drv;
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [6:0] e_sa(bit ch);
        int o = ch ? 16 : 0;
        return ptr_cfg[o] ? slave_cfg[22:16] : slave_cfg[6:0];
    endfunction
    function automatic logic [7:0] e_ra(bit ch, bit lvl);
        int o = ch ? 16 : 0;
        logic [7:0] vr = ptr_cfg[o+1] ? volreg_cfg[23:16] : volreg_cfg[7:0];
        logic [7:0] cr = ptr_cfg[o+2] ? cmdreg_cfg[23:16] : cmdreg_cfg[7:0];
        if (lvl && ptr_cfg[o+3]) return cr;
        return vr;
    endfunction
    function automatic logic [7:0] e_dat(bit ch, bit lvl, logic [7:0] d);
        int o = ch ? 16 : 0;
        if (lvl) return ptr_cfg[o+4] ? level1 : level0;
        return d;
    endfunction

    task automatic do_req(input bit v1, input bit v2, input bit lvl, input logic [7:0] d,
                          input int nk, input int late);
        bit ch = v1 ? 1'b0 : 1'b1;
        bit hsm = !fs_mode;
        int base = hsm ? 1 : 0;
        int e_st = hsm ? 2 : 1;
        int e_sp = (hsm && rsta_off) ? 2 : 1;
        int waited = 0;
        int st_snap;
        cap_n = 0; n_start = 0; n_stop = 0; nm_cnt = 0; first_per = -1; last_per = -1;
        n_done = 0; n_errp = 0; n_hichg = 0; n_both = 0; bitcnt = 0;
        nack_sel = nk; hs_b = hsm;
        @(negedge clk);
        req_vdd1 = v1; req_vdd2 = v2; req_lvl = lvl; req_data = d;
        @(negedge clk);
        req_vdd1 = 1'b0; req_vdd2 = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        if (late > 0) begin
            repeat (late) @(negedge clk);
            req_vdd2 = 1'b1; req_data = ~d;
            @(negedge clk);
            req_vdd2 = 1'b0;
        end
        while (n_done == 0 && n_errp == 0 && waited < 20000) begin
            @(negedge clk); waited++;
        end
        repeat (3) @(negedge clk);
        if (nk == 0) begin
            chk(n_done == 1 && n_errp == 0, "R9 single done pulse", n_done, 1);
            chk(cap_n == base + 3, "R4 byte count", cap_n, base + 3);
            if (hsm) chk(cap[0] == {5'b00001, mcode}, "R4 master code", cap[0], {5'b00001, mcode});
            chk(cap[base] == {e_sa(ch), 1'b0}, "R1 address byte", cap[base], {e_sa(ch), 1'b0});
            if (v1 && v2) chk(cap[base] == {e_sa(1'b0), 1'b0}, "R10 VDD1 priority", cap[base], {e_sa(1'b0), 1'b0});
            chk(cap[base+1] == e_ra(ch, lvl), lvl ? "R3 register byte" : "R2 register byte",
                cap[base+1], e_ra(ch, lvl));
            chk(cap[base+2] == e_dat(ch, lvl, d), lvl ? "R3 data byte" : "R2 data byte",
                cap[base+2], e_dat(ch, lvl, d));
            chk(first_per == 4*(int'(div_pre)+1), "R6 preamble bit period", first_per, 4*(int'(div_pre)+1));
            chk(last_per == 4*(int'(hsm ? div_hs : div_pre)+1), "R6 data bit period",
                last_per, 4*(int'(hsm ? div_hs : div_pre)+1));
            chk(n_start == e_st && n_stop == e_sp, "R5 start/stop count", {n_start, n_stop}, {e_st, e_sp});
        end else begin
            chk(n_errp == 1 && n_done == 0, "R8 err pulse without done", {n_errp, n_done}, 1);
            chk(cap_n == base + nk, "R8 bytes stop at nack", cap_n, base + nk);
            chk(n_stop == e_sp, "R8 stop after nack", n_stop, e_sp);
        end
        chk(n_both == 0, "R7 no simultaneous SCL/SDA change", n_both, 0);
        chk(n_hichg == e_st + e_sp, "R7 SDA moves with SCL high only at start/stop", n_hichg, e_st + e_sp);
        chk(!busy && scl_o && sda_o, "R11 idle bus after transfer", {busy, scl_o, sda_o}, 3'b011);
        if (late > 0) begin
            st_snap = n_start;
            repeat (200) @(negedge clk);
            chk(n_start == st_snap && !busy, "R10 request during busy ignored", n_start, st_snap);
            chk(cap[base+2] == e_dat(ch, lvl, d), "R10 first request data kept", cap[base+2], e_dat(ch, lvl, d));
        end
    endtask

    initial begin
        #(CLK_PERIOD*190000);
        n_err++;
        $display("FAIL R9 watchdog expired: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(scl_o && sda_o && !busy && !done && !err, "R11 reset state",
            {scl_o, sda_o, busy, done, err}, 5'b11000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(scl_o && sda_o && !busy, "R11 idle after reset", {scl_o, sda_o, busy}, 3'b110);

        slave_cfg = 32'h0055_0048; volreg_cfg = 32'h0021_0012;
        cmdreg_cfg = 32'h00C3_003C; level0 = 8'hA5; level1 = 8'h5A; mcode = 3'd5;
        // HS, repeated start, plain VDD1
        ptr_cfg = 32'h0000_0000; fs_mode = 0; rsta_off = 0;
        do_req(1, 0, 0, 8'h37, 0, 0);
        // HS, no repeated start, level VDD2 to command register
        ptr_cfg = 32'h001F_0000; rsta_off = 1; div_pre = 2; div_hs = 0;
        do_req(0, 1, 1, 8'h00, 0, 0);
        // FS, level VDD2 to voltage register
        ptr_cfg = 32'h0013_0000; fs_mode = 1; rsta_off = 0; div_pre = 4;
        do_req(0, 1, 1, 8'h00, 0, 0);
        // level VDD1 to command register, level 0
        ptr_cfg = 32'h0000_000C; fs_mode = 0;
        do_req(1, 0, 1, 8'h00, 0, 0);
        // nack at each byte position
        ptr_cfg = 32'h0001_0002;
        do_req(1, 0, 0, 8'h11, 1, 0);
        do_req(1, 0, 0, 8'h22, 2, 0);
        rsta_off = 1;
        do_req(0, 1, 0, 8'h33, 3, 0);
        fs_mode = 1; rsta_off = 0;
        do_req(1, 0, 0, 8'h44, 2, 0);
        // both channels at once
        fs_mode = 0; ptr_cfg = 32'h0001_0000;
        do_req(1, 1, 0, 8'h66, 0, 0);
        // request during busy
        do_req(1, 0, 0, 8'h77, 0, 150);

        for (int i = 0; i < 30; i++) begin
            bit a, b;
            int r;
            slave_cfg  = $urandom | 32'h0040_0040;
            volreg_cfg = $urandom; cmdreg_cfg = $urandom; ptr_cfg = $urandom;
            level0 = 8'($urandom); level1 = 8'($urandom); mcode = 3'($urandom);
            fs_mode = 1'($urandom); rsta_off = 1'($urandom);
            div_pre = 8'($urandom_range(0, 5)); div_hs = 8'($urandom_range(0, 3));
            a = 1'($urandom); b = 1'($urandom);
            if (!a && !b) a = 1'b1;
            r = $urandom_range(0, 7);
            do_req(a, b, 1'($urandom), 8'($urandom), (r < 3) ? r + 1 : 0, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule